// File: doc/BRIEF.md
# Remote DMA Controller

This block moves data between a host-facing data port and a local packet memory. Software sets a 16-bit start address and a 16-bit byte count, one byte at a time, picks byte or word width, and then issues a command. A write command stores each host data-port beat into memory at the current address. A read command prefetches memory into a holding register that the host consumes beat by beat. After each beat the current address moves forward and the remaining count moves down by the access width. When the remaining count reaches zero, a completion flag is raised.

An abort command stops the engine at the next clock edge. The current address keeps its value, so software can see how far the transfer got. The current address is always visible on two byte-wide outputs. The memory is a plain synchronous RAM port with byte-lane enables and one cycle of read latency. Host bus decoding, the automatic packet-fetch mode and the memory array itself are outside this block.

Top module: `rdma_ctrl`

## Requirements
- R1: After a synchronous reset the block is idle: busy, done and port_valid are 0, the current address is 0, and neither mem_re nor mem_we is asserted.
- R2: Register writes use reg_addr 0 and 1 for the start address (low byte, high byte), 2 and 3 for the byte count (low byte, high byte), and 4 for a command. Command code 001 in reg_wdata[2:0] starts a read and 010 starts a write. Either command copies the start address into the current address and the byte count into the remaining count, and clears done, at the edge where it is written.
- R3: While a write transfer is active, each cycle with port_strobe high drives mem_we in that same cycle, with mem_addr equal to the current address and mem_wdata equal to port_wdata.
- R4: In a read transfer, port_valid goes high two cycles after the command edge, and again two cycles after each accepted strobe. port_rdata then holds the memory contents at the current address.
- R5: Bit 0 of reg_addr 5 selects word mode (1) or byte mode (0). Word mode uses mem_be = 11 and a step of 2. Byte mode uses mem_be = 01 and a step of 1, and port_rdata[15:8] reads as 0. The width is captured when the command is issued; later changes to the bit do not affect that transfer.
- R6: Each accepted beat subtracts the step from the remaining count, saturating at zero. When the count reaches zero, done is set and busy clears at that same edge. In word mode an odd count therefore ends on a full word access.
- R7: A read or write command issued with a byte count of 0 sets done at its edge. It leaves busy at 0 and makes no memory access.
- R8: A command with reg_wdata[2] = 1 (abort) ends any transfer at its edge. The current address and done keep their values.
- R9: Command codes 000 and 011 have no effect: busy, done and the current address are unchanged, and a strobe in that same cycle is not accepted.
- R10: A strobe while no transfer is waiting for it is ignored. This covers the idle state and a read whose data is not yet valid. Such a strobe causes no memory write and does not move the current address.
- R11: The current address can be read at any time on cur_lo (bits 7:0) and cur_hi (bits 15:8).
- R12: mem_re and mem_we are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| port_strobe | input | 1 | Host data-port access strobe |
| port_wdata | input | 16 | Host data for write transfers |
| port_rdata | output | 16 | Prefetched data for read transfers |
| port_valid | output | 1 | port_rdata holds a beat awaiting a strobe |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Completion flag |
| cur_lo | output | 8 | Current address, low byte |
| cur_hi | output | 8 | Current address, high byte |
| mem_addr | output | 16 | Memory byte address |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 2 | Memory byte-lane enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after mem_re |

## Verification
Register and command writes take effect at the edge that ends the write cycle. The bench samples on the falling edge right after that, where the loaded current address, done and busy must already show the new values. mem_we and mem_addr follow the strobe in the same cycle, so they are checked shortly after the strobe is driven and before the next rising edge. port_valid is sampled on the first, second and third falling edges after a command or strobe, and the expected pattern is 0, 0, 1 (two cycles of latency). Completion, address advance and written memory bytes are checked once the final beat's edge has passed. Expected values come from a bench-side shadow memory and arithmetic on the step and count.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    // register select codes on the host register port
    localparam logic [2:0] RA_START_LO = 3'd0;
    localparam logic [2:0] RA_START_HI = 3'd1;
    localparam logic [2:0] RA_CNT_LO   = 3'd2;
    localparam logic [2:0] RA_CNT_HI   = 3'd3;
    localparam logic [2:0] RA_CMD      = 3'd4;
    localparam logic [2:0] RA_CFG      = 3'd5;

    typedef enum logic [1:0] {
        OP_NOP,
        OP_READ,
        OP_WRITE,
        OP_ABORT
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_READY,
        ST_WRITE
    } state_e;

    typedef struct packed {
        logic valid;
        op_e  op;
        logic word;
    } cmd_t;

    // bit 2 set aborts; 001 read, 010 write; 000 and 011 do nothing here
    function automatic op_e decode_op(input logic [2:0] code);
        op_e r;
        if (code[2]) begin
            r = OP_ABORT;
        end else begin
            case (code[1:0])
                2'b01:   r = OP_READ;
                2'b10:   r = OP_WRITE;
                default: r = OP_NOP;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [ADDR_W-1:0] start_addr,
    output logic [CNT_W-1:0]  byte_cnt,
    output cmd_t              cmd
);
    localparam int AHI = ADDR_W - 8;
    localparam int CHI = CNT_W - 8;

    logic word_cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_addr <= '0;
            byte_cnt   <= '0;
            word_cfg   <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_START_LO: start_addr[7:0]        <= reg_wdata;
                RA_START_HI: start_addr[ADDR_W-1:8] <= reg_wdata[AHI-1:0];
                RA_CNT_LO:   byte_cnt[7:0]          <= reg_wdata;
                RA_CNT_HI:   byte_cnt[CNT_W-1:8]    <= reg_wdata[CHI-1:0];
                RA_CFG:      word_cfg               <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        cmd.valid = reg_wr && (reg_addr == RA_CMD);
        cmd.op    = decode_op(reg_wdata[2:0]);
        cmd.word  = word_cfg;
    end

endmodule

// File: rtl/rdma_lanes.sv
module rdma_lanes #(
    parameter int LANES = 2,
    localparam int DATA_W = 8 * LANES,
    localparam int SW     = $clog2(LANES + 1)
) (
    input  logic              word,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] rd_data,
    output logic [SW-1:0]     step
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == 0) begin : g_first
            assign be[i]         = 1'b1;
            assign rd_data[7:0]  = mem_rdata[7:0];
        end else begin : g_upper
            assign be[i]           = word;
            assign rd_data[8*i+:8] = word ? mem_rdata[8*i+:8] : 8'h00;
        end
    end

    assign step = word ? SW'(LANES) : SW'(1);

endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int LANES  = 2,
    localparam int DATA_W = 8 * LANES,
    localparam int SW     = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              port_strobe,
    input  logic [SW-1:0]     step,
    input  logic [DATA_W-1:0] lane_rdata,
    output logic              word_q,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              busy,
    output logic              done,
    output logic              port_valid,
    output logic [DATA_W-1:0] port_rdata,
    output logic              mem_re,
    output logic              mem_we
);
    state_e             st;
    logic [CNT_W-1:0]   remaining;
    logic [CNT_W-1:0]   rem_next;
    logic [CNT_W-1:0]   step_c;
    logic               accept;

    assign step_c   = CNT_W'(step);
    assign rem_next = (remaining > step_c) ? (remaining - step_c) : '0;
    assign accept   = port_strobe && !cmd.valid &&
                      ((st == ST_WRITE) || (st == ST_READY));

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cur_addr   <= '0;
            remaining  <= '0;
            word_q     <= 1'b0;
            done       <= 1'b0;
            port_rdata <= '0;
        end else if (cmd.valid) begin
            case (cmd.op)
                OP_READ, OP_WRITE: begin
                    cur_addr  <= start_addr;
                    remaining <= byte_cnt;
                    word_q    <= cmd.word;
                    done      <= (byte_cnt == '0);
                    if (byte_cnt == '0)
                        st <= ST_IDLE;
                    else
                        st <= (cmd.op == OP_READ) ? ST_FETCH : ST_WRITE;
                end
                OP_ABORT: st <= ST_IDLE;
                default: ;
            endcase
        end else begin
            case (st)
                ST_FETCH: st <= ST_WAIT;
                ST_WAIT: begin
                    port_rdata <= lane_rdata;
                    st         <= ST_READY;
                end
                ST_READY, ST_WRITE: begin
                    if (accept) begin
                        cur_addr  <= cur_addr + ADDR_W'(step);
                        remaining <= rem_next;
                        if (rem_next == '0) begin
                            done <= 1'b1;
                            st   <= ST_IDLE;
                        end else begin
                            st <= (st == ST_READY) ? ST_FETCH : ST_WRITE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy       = (st != ST_IDLE);
    assign port_valid = (st == ST_READY);
    assign mem_re     = (st == ST_FETCH);
    assign mem_we     = accept && (st == ST_WRITE);

endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int LANES  = 2,
    localparam int DATA_W = 8 * LANES,
    localparam int SW     = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              port_strobe,
    input  logic [DATA_W-1:0] port_wdata,
    output logic [DATA_W-1:0] port_rdata,
    output logic              port_valid,
    output logic              busy,
    output logic              done,
    output logic [7:0]        cur_lo,
    output logic [ADDR_W-9:0] cur_hi,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    cmd_t              cmd;
    logic [ADDR_W-1:0] start_addr;
    logic [CNT_W-1:0]  byte_cnt;
    logic              word_q;
    logic [SW-1:0]     step;
    logic [DATA_W-1:0] lane_rdata;
    logic [ADDR_W-1:0] cur_addr;

    rdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .start_addr (start_addr),
        .byte_cnt   (byte_cnt),
        .cmd        (cmd)
    );

    rdma_lanes #(.LANES(LANES)) lanes_i (
        .word      (word_q),
        .mem_rdata (mem_rdata),
        .be        (mem_be),
        .rd_data   (lane_rdata),
        .step      (step)
    );

    rdma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LANES(LANES)) engine_i (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .start_addr  (start_addr),
        .byte_cnt    (byte_cnt),
        .port_strobe (port_strobe),
        .step        (step),
        .lane_rdata  (lane_rdata),
        .word_q      (word_q),
        .cur_addr    (cur_addr),
        .busy        (busy),
        .done        (done),
        .port_valid  (port_valid),
        .port_rdata  (port_rdata),
        .mem_re      (mem_re),
        .mem_we      (mem_we)
    );

    assign cur_lo    = cur_addr[7:0];
    assign cur_hi    = cur_addr[ADDR_W-1:8];
    assign mem_addr  = cur_addr;
    assign mem_wdata = port_wdata;

endmodule

// File: rtl/rdma_checker.sv
module rdma_checker #(
    parameter int ADDR_W = 16,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [2:0]        cmd_code,
    input logic              port_strobe,
    input logic              busy,
    input logic              done,
    input logic              port_valid,
    input logic              mem_re,
    input logic              mem_we,
    input logic [LANES-1:0]  mem_be,
    input logic [7:0]        cur_lo,
    input logic [ADDR_W-9:0] cur_hi
);
    logic [ADDR_W-1:0] cur;
    logic              cmd_wr;

    assign cur    = {cur_hi, cur_lo};
    assign cmd_wr = reg_wr && (reg_addr == 3'd4);

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !port_valid && cur == '0));

    assert_valid_busy_R4: assert property (@(posedge clk) disable iff (rst)
        port_valid |-> busy);

    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> cur == ADDR_W'($past(cur) + $countones($past(mem_be))));

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !busy);

    assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_code[2]) |=> (!busy && $stable(cur) && $stable(done)));

    assert_nop_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !cmd_code[2] && (cmd_code[1:0] == 2'b00 || cmd_code[1:0] == 2'b11))
        |=> ($stable(busy) && $stable(cur) && $stable(done)));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_we && !mem_re));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cmd_wr) |=> $stable(cur));

    assert_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we));

endmodule

bind rdma_ctrl rdma_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .cmd_code    (reg_wdata[2:0]),
    .port_strobe (port_strobe),
    .busy        (busy),
    .done        (done),
    .port_valid  (port_valid),
    .mem_re      (mem_re),
    .mem_we      (mem_we),
    .mem_be      (mem_be),
    .cur_lo      (cur_lo),
    .cur_hi      (cur_hi)
);

// File: tb/rdma_ctrl_tb.sv
module rdma_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        port_strobe = 1'b0;
    logic [15:0] port_wdata = '0;
    logic [15:0] port_rdata;
    logic        port_valid;
    logic        busy;
    logic        done;
    logic [7:0]  cur_lo;
    logic [7:0]  cur_hi;
    logic [15:0] mem_addr;
    logic        mem_re;
    logic        mem_we;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    logic [7:0] mem    [256];
    logic [7:0] shadow [256];

    always #5 clk = ~clk;

    rdma_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .port_strobe(port_strobe), .port_wdata(port_wdata),
        .port_rdata(port_rdata), .port_valid(port_valid), .busy(busy), .done(done),
        .cur_lo(cur_lo), .cur_hi(cur_hi), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // synchronous RAM model, byte addressed, one cycle read latency
    always @(posedge clk) begin
        if (mem_we) begin
            if (mem_be[0]) mem[mem_addr[7:0]]        <= mem_wdata[7:0];
            if (mem_be[1]) mem[mem_addr[7:0] + 8'd1] <= mem_wdata[15:8];
        end
        if (mem_re)
            mem_rdata <= {mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    function automatic logic [15:0] cur_now();
        return {cur_hi, cur_lo};
    endfunction

    function automatic int beats(input logic [15:0] c, input logic w);
        int st = w ? 2 : 1;
        return (int'(c) + st - 1) / st;
    endfunction

    function automatic logic [15:0] exp_rd(input logic [15:0] a, input logic w);
        return w ? {shadow[a[7:0] + 8'd1], shadow[a[7:0]]} : {8'h00, shadow[a[7:0]]};
    endfunction

    // all tasks start and end at a falling edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic strobe(input logic [15:0] d);
        port_strobe = 1'b1; port_wdata = d;
        @(negedge clk);
        port_strobe = 1'b0;
    endtask

    task automatic setup(input logic [15:0] s, input logic [15:0] c, input logic w);
        wr(3'd0, s[7:0]); wr(3'd1, s[15:8]);
        wr(3'd2, c[7:0]); wr(3'd3, c[15:8]);
        wr(3'd5, {7'd0, w});
    endtask

    task automatic mem_compare(input string r);
        int bad = 0;
        for (int i = 0; i < 256; i++)
            if (mem[i] !== shadow[i]) bad++;
        chk(r, bad, 0);
    endtask

    task automatic do_write(input logic [15:0] s, input logic [15:0] c, input logic w);
        int n = beats(c, w);
        int st = w ? 2 : 1;
        setup(s, c, w);
        wr(3'd4, 8'h02);
        chk("R2 start loaded", cur_now(), s);
        if (n == 0) begin
            chk("R7 zero count done", done, 1);
            chk("R7 zero count idle", busy, 0);
        end
        for (int k = 0; k < n; k++) begin
            logic [15:0] d = 16'($urandom);
            logic [15:0] a = 16'(s + k * st);
            port_strobe = 1'b1; port_wdata = d;
            #1;
            chk("R3 mem_we with strobe", mem_we, 1);
            chk("R3 mem_addr", mem_addr, a);
            chk("R5 lane enables", mem_be, w ? 2'b11 : 2'b01);
            chk("R12 no read during write", mem_re, 0);
            shadow[a[7:0]] = d[7:0];
            if (w) shadow[a[7:0] + 8'd1] = d[15:8];
            @(negedge clk);
            port_strobe = 1'b0;
        end
        chk("R6 done after write", done, 1);
        chk("R6 idle after write", busy, 0);
        chk("R5 final address", cur_now(), 16'(s + n * st));
        mem_compare("R3 memory contents");
    endtask

    task automatic do_read(input logic [15:0] s, input logic [15:0] c, input logic w);
        int n = beats(c, w);
        int st = w ? 2 : 1;
        setup(s, c, w);
        wr(3'd4, 8'h01);
        chk("R2 start loaded", cur_now(), s);
        if (n == 0) begin
            chk("R7 zero count done", done, 1);
            chk("R7 zero count no fetch", {busy, mem_re}, 0);
        end
        for (int k = 0; k < n; k++) begin
            logic v0, v1;
            logic [15:0] a = 16'(s + k * st);
            v0 = port_valid;
            @(negedge clk);
            v1 = port_valid;
            @(negedge clk);
            chk("R4 valid latency", {v0, v1, port_valid}, 3'b001);
            chk("R4 read data", port_rdata, exp_rd(a, w));
            strobe(16'h0);
        end
        chk("R6 done after read", done, 1);
        chk("R6 idle after read", busy, 0);
        chk("R5 final address", cur_now(), 16'(s + n * st));
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'd5150);
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 8'(i * 7 + 3);
            shadow[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 valid", port_valid, 0);
        chk("R1 cur address", cur_now(), 16'h0000);
        chk("R1 no memory access", {mem_re, mem_we}, 0);

        // directed transfers
        do_write(16'h0010, 16'd3, 1'b0);
        do_write(16'h00F0, 16'd5, 1'b1);
        do_read(16'h0010, 16'd3, 1'b0);
        do_read(16'h00EF, 16'd6, 1'b1);
        do_write(16'h0030, 16'd0, 1'b1);
        do_read(16'h0030, 16'd0, 1'b0);

        // R11 readback of both bytes
        setup(16'hA5C3, 16'd2, 1'b0);
        wr(3'd4, 8'h02);
        chk("R11 cur_lo", cur_lo, 8'hC3);
        chk("R11 cur_hi", cur_hi, 8'hA5);
        strobe(16'h0011); shadow[8'hC3] = 8'h11;
        chk("R11 cur_lo after beat", cur_lo, 8'hC4);
        strobe(16'h0022); shadow[8'hC4] = 8'h22;
        chk("R6 done", done, 1);

        // R9 no-op codes keep state
        wr(3'd4, 8'h00);
        chk("R9 code 000 done", done, 1);
        chk("R9 code 000 addr", cur_now(), 16'hA5C5);
        wr(3'd4, 8'h03);
        chk("R9 code 011 done", done, 1);
        chk("R9 code 011 busy", busy, 0);
        setup(16'h0050, 16'd4, 1'b0);
        wr(3'd4, 8'h02);
        wr(3'd4, 8'h00);
        chk("R9 nop keeps busy", busy, 1);
        chk("R9 nop keeps addr", cur_now(), 16'h0050);
        // R9 strobe together with a no-op is not accepted
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h03; port_strobe = 1'b1; port_wdata = 16'h00EE;
        #1;
        chk("R9 strobe with nop no write", mem_we, 0);
        @(negedge clk);
        reg_wr = 1'b0; port_strobe = 1'b0;
        chk("R9 strobe with nop addr", cur_now(), 16'h0050);

        // R8 abort mid write
        setup(16'h0040, 16'd10, 1'b1);
        wr(3'd4, 8'h02);
        strobe(16'hBEEF);
        shadow[8'h40] = 8'hEF; shadow[8'h41] = 8'hBE;
        wr(3'd4, 8'h04);
        chk("R8 abort idle", busy, 0);
        chk("R8 abort keeps addr", cur_now(), 16'h0042);
        chk("R8 abort keeps done", done, 0);
        // R10 strobe while idle
        port_strobe = 1'b1; port_wdata = 16'h1234;
        #1;
        chk("R10 idle strobe no write", mem_we, 0);
        @(negedge clk);
        port_strobe = 1'b0;
        chk("R10 idle strobe addr", cur_now(), 16'h0042);
        mem_compare("R10 memory untouched");

        // R8 abort during read prefetch, R10 early strobe
        setup(16'h0020, 16'd4, 1'b0);
        wr(3'd4, 8'h01);
        strobe(16'h0);
        chk("R10 early strobe addr", cur_now(), 16'h0020);
        wr(3'd4, 8'h07);
        chk("R8 read abort idle", busy, 0);
        repeat (3) @(negedge clk);
        chk("R8 no data after abort", port_valid, 0);
        chk("R8 read abort addr", cur_now(), 16'h0020);

        // R5 width latched at command
        setup(16'h0080, 16'd4, 1'b1);
        wr(3'd4, 8'h02);
        wr(3'd5, 8'h00);
        port_strobe = 1'b1; port_wdata = 16'hCAFE;
        #1;
        chk("R5 latched word lanes", mem_be, 2'b11);
        @(negedge clk);
        port_strobe = 1'b0;
        shadow[8'h80] = 8'hFE; shadow[8'h81] = 8'hCA;
        chk("R5 latched word step", cur_now(), 16'h0082);
        strobe(16'hF00D);
        shadow[8'h82] = 8'h0D; shadow[8'h83] = 8'hF0;
        chk("R6 done after latched", done, 1);
        mem_compare("R5 memory after latched");

        // random transfers
        for (int t = 0; t < 40; t++) begin
            logic [15:0] s = 16'($urandom);
            logic [15:0] c = 16'($urandom_range(0, 9));
            logic        w = 1'($urandom);
            if ($urandom_range(0, 1) == 0) do_write(s, c, w);
            else                           do_read(s, c, w);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule